// File: doc/BRIEF.md
# Chained Vector Multiply-Add Engine

This block computes the saxpy update y(i) = a*x(i) + y(i) on 32-bit integer vectors of up to 64 elements. Two internal vector register files hold the X and Y operands. They are filled through a load port before a run and read back through a result port after it. A start pulse latches the vector length and the scalar a. The engine then issues one element per clock into a multiply pipeline.

The multiply pipeline feeds each product straight into an add pipeline, so no product is written to a register file on the way. The y(i) operand travels beside its element through the multiply stages, which means it reaches the adder on the same cycle as its product. Once both pipelines are full, one multiply and one add retire on every clock. Each sum is written back over y(i) in the Y file. A done flag rises one cycle after the last write and stays high until the next accepted start. All arithmetic wraps modulo 2^32.

Top module: `vsaxpy_top`

## Requirements
- R1: After reset, `done_o` and `busy_o` are both low.
- R2: After a run of length n, Y element i holds (a*x(i) + y(i)) mod 2^32 for every i below n, using the operands loaded before the start.
- R3: Y elements at index n and above keep the values they held before the run.
- R4: When a start with length n is accepted at a clock edge, `busy_o` is high from that edge on. `done_o` is low from that edge on. `done_o` rises and `busy_o` falls together exactly MUL_STAGES + ADD_STAGES + n + 1 edges later.
- R5: A start pulse while `busy_o` is high is ignored: the running length, its results and its completion time are unchanged.
- R6: A start pulse whose `len_i` is 0 or greater than 64 is ignored: `busy_o` stays low and `done_o` keeps its value.
- R7: Load writes presented while `busy_o` is high are ignored and change no register element.
- R8: Sums are written back in increasing index order on consecutive clocks, with no gap between element k and element k+1.
- R9: With `busy_o` low, `ld_we_i` writes `ld_data_i` into element `ld_idx_i` at the next edge. `ld_sel_i` = 0 selects the X file and 1 selects the Y file. `rd_data_o` shows Y element `rd_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse for a run |
| len_i | input | 7 | Vector length, valid range 1 to 64 |
| scalar_i | input | 32 | Scalar multiplier a, latched at start |
| ld_we_i | input | 1 | Load write enable |
| ld_sel_i | input | 1 | Load target: 0 = X file, 1 = Y file |
| ld_idx_i | input | 6 | Load element index |
| ld_data_i | input | 32 | Load data |
| rd_idx_i | input | 6 | Result read index into the Y file |
| rd_data_o | output | 32 | Y element at `rd_idx_i` |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | High from the end of a run until the next accepted start |

## Verification
The finish flag is due exactly MUL_STAGES + ADD_STAGES + n + 1 rising edges after the edge that accepts the start. The bench therefore counts edges from that accepting edge and samples `done_o` at each falling edge, so the count it compares is exact. The busy flag is due one edge after the start and is sampled at the next falling edge. Loads take effect at the following edge. Y contents are read back through the combinational read port only after `done_o` has been seen. Stray starts and loads are injected a few cycles into a run, and their lack of effect is judged from the finish count and the read-back values.

// File: rtl/vsaxpy_pkg.sv
package vsaxpy_pkg;

    localparam int DATA_W   = 32;
    localparam int VLEN     = 64;
    localparam int IDX_W    = $clog2(VLEN);
    localparam int LEN_W    = IDX_W + 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LEN_W-1:0]  len_t;

    // one element travelling through the multiply stages
    typedef struct packed {
        logic  valid;
        idx_t  idx;
        word_t prod;
        word_t addend;
    } mul_lane_t;

    // one element travelling through the add stages
    typedef struct packed {
        logic  valid;
        idx_t  idx;
        word_t sum;
    } add_lane_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } run_state_e;

    function automatic logic length_in_range(len_t n);
        return (n != '0) && (int'(n) <= VLEN);
    endfunction

    function automatic logic is_last(idx_t idx, len_t n);
        return {1'b0, idx} == (n - len_t'(1));
    endfunction

endpackage

// File: rtl/vsaxpy_vregs.sv
module vsaxpy_vregs
    import vsaxpy_pkg::*;
#(
    parameter int NRD = 1
) (
    input  logic  clk,
    input  logic  we,
    input  idx_t  wr_idx,
    input  word_t wr_data,
    input  idx_t  rd_idx  [NRD],
    output word_t rd_data [NRD]
);

    word_t mem [VLEN];

    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_data;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = mem[rd_idx[r]];
    end

endmodule

// File: rtl/vsaxpy_mul_pipe.sv
module vsaxpy_mul_pipe
    import vsaxpy_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  idx_t      in_idx,
    input  word_t     scalar,
    input  word_t     x_elem,
    input  word_t     y_elem,
    output mul_lane_t out_lane
);

    mul_lane_t st [STAGES];
    mul_lane_t entry;

    // product formed in the first stage, later stages carry it; the
    // addend rides along so it emerges aligned with its product
    always_comb begin
        entry.valid  = in_valid;
        entry.idx    = in_idx;
        entry.prod   = scalar * x_elem;
        entry.addend = y_elem;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                st[s] <= '0;
            end else if (s == 0) begin
                st[s] <= entry;
            end else begin
                st[s] <= st[s-1];
            end
        end
    end

    assign out_lane = st[STAGES-1];

endmodule

// File: rtl/vsaxpy_add_pipe.sv
module vsaxpy_add_pipe
    import vsaxpy_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  mul_lane_t in_lane,
    output add_lane_t out_lane
);

    add_lane_t st [STAGES];
    add_lane_t entry;

    always_comb begin
        entry.valid = in_lane.valid;
        entry.idx   = in_lane.idx;
        entry.sum   = in_lane.prod + in_lane.addend;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                st[s] <= '0;
            end else if (s == 0) begin
                st[s] <= entry;
            end else begin
                st[s] <= st[s-1];
            end
        end
    end

    assign out_lane = st[STAGES-1];

endmodule

// File: rtl/vsaxpy_ctrl.sv
module vsaxpy_ctrl
    import vsaxpy_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  len_t  len_in,
    input  word_t scalar_in,
    input  logic  wb_valid,
    input  idx_t  wb_idx,
    output logic  busy,
    output logic  done,
    output logic  issue_valid,
    output idx_t  issue_idx,
    output len_t  len_q,
    output word_t scalar_q
);

    run_state_e state;
    idx_t       cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            scalar_q <= '0;
            done     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start && length_in_range(len_in)) begin
                        state    <= ST_ISSUE;
                        len_q    <= len_in;
                        scalar_q <= scalar_in;
                        cnt      <= '0;
                        done     <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    cnt <= cnt + idx_t'(1);
                    if (is_last(cnt, len_q)) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (wb_valid && is_last(wb_idx, len_q)) state <= ST_FINISH;
                end
                ST_FINISH: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign issue_valid = (state == ST_ISSUE);
    assign issue_idx   = cnt;

endmodule

// File: rtl/vsaxpy_top.sv
module vsaxpy_top
    import vsaxpy_pkg::*;
#(
    parameter int MUL_STAGES = 4,
    parameter int ADD_STAGES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [6:0]  len_i,
    input  logic [31:0] scalar_i,
    input  logic        ld_we_i,
    input  logic        ld_sel_i,
    input  logic [5:0]  ld_idx_i,
    input  logic [31:0] ld_data_i,
    input  logic [5:0]  rd_idx_i,
    output logic [31:0] rd_data_o,
    output logic        busy_o,
    output logic        done_o
);

    localparam int TOTAL_DEPTH = MUL_STAGES + ADD_STAGES;

    logic      busy;
    logic      done;
    logic      issue_valid;
    idx_t      issue_idx;
    len_t      len_q;
    word_t     scalar_q;
    mul_lane_t mul_out;
    add_lane_t add_out;
    logic      wb_valid;
    idx_t      wb_idx;

    // ---------------- control ----------------
    vsaxpy_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start_i),
        .len_in      (len_t'(len_i)),
        .scalar_in   (word_t'(scalar_i)),
        .wb_valid    (wb_valid),
        .wb_idx      (wb_idx),
        .busy        (busy),
        .done        (done),
        .issue_valid (issue_valid),
        .issue_idx   (issue_idx),
        .len_q       (len_q),
        .scalar_q    (scalar_q)
    );

    // ---------------- register files ----------------
    logic  x_we;
    idx_t  x_rd_idx  [1];
    word_t x_rd_data [1];

    logic  y_we;
    idx_t  y_wr_idx;
    word_t y_wr_data;
    idx_t  y_rd_idx  [2];
    word_t y_rd_data [2];

    logic  load_ok;
    assign load_ok = ld_we_i && !busy;

    assign x_we        = load_ok && !ld_sel_i;
    assign x_rd_idx[0] = issue_idx;

    // write-back owns the Y write port while a run is active
    always_comb begin
        if (wb_valid) begin
            y_we      = 1'b1;
            y_wr_idx  = wb_idx;
            y_wr_data = add_out.sum;
        end else begin
            y_we      = load_ok && ld_sel_i;
            y_wr_idx  = idx_t'(ld_idx_i);
            y_wr_data = word_t'(ld_data_i);
        end
    end

    assign y_rd_idx[0] = issue_idx;
    assign y_rd_idx[1] = idx_t'(rd_idx_i);

    vsaxpy_vregs #(.NRD(1)) u_xregs (
        .clk     (clk),
        .we      (x_we),
        .wr_idx  (idx_t'(ld_idx_i)),
        .wr_data (word_t'(ld_data_i)),
        .rd_idx  (x_rd_idx),
        .rd_data (x_rd_data)
    );

    vsaxpy_vregs #(.NRD(2)) u_yregs (
        .clk     (clk),
        .we      (y_we),
        .wr_idx  (y_wr_idx),
        .wr_data (y_wr_data),
        .rd_idx  (y_rd_idx),
        .rd_data (y_rd_data)
    );

    // ---------------- chained pipelines ----------------
    vsaxpy_mul_pipe #(.STAGES(MUL_STAGES)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_valid (issue_valid),
        .in_idx   (issue_idx),
        .scalar   (scalar_q),
        .x_elem   (x_rd_data[0]),
        .y_elem   (y_rd_data[0]),
        .out_lane (mul_out)
    );

    vsaxpy_add_pipe #(.STAGES(ADD_STAGES)) u_add (
        .clk      (clk),
        .rst      (rst),
        .in_lane  (mul_out),
        .out_lane (add_out)
    );

    assign wb_valid  = add_out.valid;
    assign wb_idx    = add_out.idx;

    assign rd_data_o = y_rd_data[1];
    assign busy_o    = busy;
    assign done_o    = done;

    initial begin
        if (MUL_STAGES < 1 || ADD_STAGES < 1 || TOTAL_DEPTH < 2)
            $error("vsaxpy_top: pipeline depths must be at least 1");
    end

endmodule

// File: rtl/vsaxpy_chk.sv
module vsaxpy_chk
    import vsaxpy_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [6:0] len_i,
    input logic       busy_o,
    input logic       done_o,
    input len_t       len_q,
    input logic       wb_valid,
    input idx_t       wb_idx
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o));

    // R4
    finish_together_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $fell(busy_o));

    // R5
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(len_q));

    // R6
    bad_length_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && (len_i == 7'd0 || len_i > 7'd64)) |=> (!busy_o && $stable(done_o)));

    // R8
    wb_in_order_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && ({1'b0, wb_idx} != len_q - len_t'(1)))
        |=> (wb_valid && wb_idx == $past(wb_idx) + idx_t'(1)));

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

bind vsaxpy_top vsaxpy_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .len_i    (len_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .len_q    (len_q),
    .wb_valid (wb_valid),
    .wb_idx   (wb_idx)
);

// File: tb/tb_vsaxpy_top.sv
`timescale 1ns/1ps
module tb_vsaxpy_top;

    localparam int MS = 4;
    localparam int AS = 3;
    localparam int N  = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [6:0]  len_i;
    logic [31:0] scalar_i;
    logic        ld_we_i;
    logic        ld_sel_i;
    logic [5:0]  ld_idx_i;
    logic [31:0] ld_data_i;
    logic [5:0]  rd_idx_i;
    logic [31:0] rd_data_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] mx [N];
    logic [31:0] my [N];

    always #10 clk = ~clk;

    vsaxpy_top #(.MUL_STAGES(MS), .ADD_STAGES(AS)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
        .scalar_i(scalar_i), .ld_we_i(ld_we_i), .ld_sel_i(ld_sel_i),
        .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [31:0] ref_mac(logic [31:0] a, logic [31:0] x, logic [31:0] y);
        logic [63:0] p;
        p = 64'(a) * 64'(x);
        return p[31:0] + y;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(logic sel, int idx, logic [31:0] v);
        @(negedge clk);
        ld_we_i = 1'b1; ld_sel_i = sel; ld_idx_i = 6'(idx); ld_data_i = v;
        @(negedge clk);
        ld_we_i = 1'b0;
        if (sel) my[idx] = v; else mx[idx] = v;
    endtask

    task automatic read_all_y(string req_lo, string req_hi, int n);
        for (int i = 0; i < N; i++) begin
            rd_idx_i = 6'(i);
            #1;
            check((i < n) ? req_lo : req_hi, rd_data_o, my[i]);
        end
    endtask

    // runs saxpy; optional stray start / stray load injected mid-run
    task automatic run(int n, logic [31:0] a, bit stray);
        int cyc;
        logic [31:0] a_ref;
        a_ref = a;
        @(negedge clk);
        start_i = 1'b1; len_i = 7'(n); scalar_i = a;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        // R4: busy is high one edge after the start
        check("R4 busy", 32'(busy_o), 32'd1);
        check("R4 done low", 32'(done_o), 32'd0);
        cyc = 0;
        while (1) begin
            if (stray && cyc == 2) begin
                // R5 and R7: these must be ignored
                start_i = 1'b1; len_i = 7'd3; scalar_i = 32'hDEAD;
                ld_we_i = 1'b1; ld_sel_i = 1'b1; ld_idx_i = 6'd63; ld_data_i = 32'h1234_5678;
            end else begin
                start_i = 1'b0; ld_we_i = 1'b0;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start_i = 1'b0; ld_we_i = 1'b0;
            if (done_o || cyc > 400) break;
        end
        check(stray ? "R5 cycles" : "R4 cycles", 32'(cyc), 32'(MS + AS + n + 1));
        check("R4 busy low", 32'(busy_o), 32'd0);
        for (int i = 0; i < n; i++) my[i] = ref_mac(a_ref, mx[i], my[i]);
        read_all_y(stray ? "R2/R5" : "R2", stray ? "R3/R7" : "R3", n);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5A5A_1357);
        rst = 1'b1; start_i = 0; len_i = 0; scalar_i = 0;
        ld_we_i = 0; ld_sel_i = 0; ld_idx_i = 0; ld_data_i = 0; rd_idx_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 done", 32'(done_o), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < N; i++) begin
            load(1'b0, i, $urandom);
            load(1'b1, i, $urandom);
        end
        // R9: Y readback after load
        rd_idx_i = 6'd5; #1;
        check("R9 load/read", rd_data_o, my[5]);

        // boundary: length 1
        run(1, 32'd7, 0);
        // boundary: full length with wrap-around operands
        load(1'b0, 0, 32'hFFFF_FFFF); load(1'b1, 0, 32'h0000_0001);
        load(1'b0, 63, 32'h8000_0000); load(1'b1, 63, 32'h8000_0000);
        run(64, 32'hFFFF_FFFF, 0);

        // R6: bad lengths ignored, done stays high
        foreach (len_i[k]) begin end
        @(negedge clk); start_i = 1'b1; len_i = 7'd0;
        @(negedge clk); start_i = 1'b0;
        check("R6 len0 busy", 32'(busy_o), 32'd0);
        check("R6 len0 done", 32'(done_o), 32'd1);
        @(negedge clk); start_i = 1'b1; len_i = 7'd65;
        @(negedge clk); start_i = 1'b0;
        check("R6 len65 busy", 32'(busy_o), 32'd0);
        check("R6 len65 done", 32'(done_o), 32'd1);

        // R5 / R7: stray start and load during run
        run(40, 32'd3, 1);

        // random runs
        for (int r = 0; r < 6; r++) begin
            int n;
            n = 1 + int'($urandom % 64);
            for (int i = 0; i < 8; i++) load(1'b0, int'($urandom % 64), $urandom);
            run(n, $urandom, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule